// File: doc/BRIEF.md
# Caption Text Cursor and Scroll Controller

This block tracks where the next caption character lands in a character memory of rows by 32 columns, which rows are currently shown, and how far a smooth scroll has progressed. Upstream logic decodes the caption byte stream and hands the block one event per cycle: a printable character, a carriage return, a start-text or resume-text command, a roll-up command with a row count of 2, 3 or 4, a base-row set, or a notice that another channel has taken over the stream. The block answers with a registered write strobe, carrying the row and column for the character memory. It also raises one-cycle requests to clear the memory or to shift its rows up by one, and it reports the visible window and a scanline offset for the display path.

Two fill policies are supported. In text mode the window is a programmable number of rows ending at the base row. Returns walk the cursor down from the top of the window, and once the cursor sits on the base row, each further return scrolls. In roll-up mode the cursor stays on the base row. Every return scrolls, and the visible area grows by one row per return until it reaches the commanded count. After that, the top row drops out. A scroll moves the picture up one scanline per frame strobe until a whole character row has passed. A return that arrives mid-scroll abandons the rest of that scroll.

Top module: `cap_row_scroll_ctrl`

## Requirements
- R1: After reset the cursor is at row 0, column 0. The block is in text mode and not frozen, the base row is 14 and no scroll is active (offset 0). All request strobes are low, and with a 15-row window setting the visible area is rows 0 to 14.
- R2: A character event (code 1) while not frozen gives, one cycle later, a single-cycle write strobe that carries the cursor row and column. The column then moves up by one.
- R3: A character at column 31 is written at column 31, and the column stays at 31. Text never wraps.
- R4: In text mode, a return (code 2) with the cursor above the base row moves the cursor down one row to column 0. No shift request is raised.
- R5: In text mode, a return with the cursor on the base row raises a one-cycle shift request and starts a scroll at offset 0. The cursor stays on the base row at column 0.
- R6: Each frame strobe during a scroll adds one to the offset. The strobe that would bring the offset to the scanlines-per-row value ends the scroll instead and sets the offset to 0. That value is 15, or 13 when the short-row input is high. A frame strobe has no effect while no scroll is active.
- R7: A return that arrives during a scroll drops the remaining scanlines: the offset goes back to 0 and a fresh shift and scroll begin.
- R8: Start-text (code 3) raises a one-cycle clear request. It selects text mode, unfreezes the block, cancels any scroll and puts the cursor at the top row of the text window, column 0.
- R9: A channel-interrupt event (code 7) freezes the block. Characters and returns then cause no write, no shift and no cursor movement. Resume-text (code 4) unfreezes the block and selects text mode, and writing continues at the saved row and column.
- R10: Roll-up (code 5) with an argument of 2, 3 or 4 selects roll-up mode with that row count. It cancels any scroll, unfreezes the block and puts the cursor on the base row at column 0, with one row visible whose top is the base row. Any other argument is ignored.
- R11: In roll-up mode every return raises a shift request and returns the cursor to column 0. The visible row count grows by one up to the commanded count, and the visible top is the base row plus one minus that count.
- R12: Base-set (code 6) with an argument below 15 makes the argument the base row, moves the cursor there at column 0 and cancels any scroll. A larger argument is ignored.
- R13: The text window has cfg_win_rows rows, where 0 counts as 1. It is further limited to base row plus one, and its top is the base row plus one minus the window size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_code | input | 3 | Event kind (codes in the requirements) |
| ev_arg | input | 4 | Row count for roll-up, row index for base-set |
| frame_strobe | input | 1 | One pulse per displayed frame |
| cfg_win_rows | input | 4 | Text window height in rows |
| cfg_short_rows | input | 1 | 13 scanlines per row instead of 15 |
| wr_en | output | 1 | Character memory write strobe |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 5 | Column of the write |
| cur_row | output | 4 | Cursor row |
| cur_col | output | 5 | Cursor column |
| clr_req | output | 1 | Clear-memory request, one cycle |
| shift_req | output | 1 | Row-shift request, one cycle |
| disp_top | output | 4 | First visible row |
| disp_rows | output | 4 | Number of visible rows |
| scroll_active | output | 1 | Smooth scroll in progress |
| scroll_ofs | output | 4 | Current scanline offset of the scroll |
| frozen | output | 1 | Processing held by another channel |
| roll_mode | output | 1 | Roll-up mode selected |

## Verification
The offset-bound assertion assumes that the short-row input does not change while a scroll is running. If it fell from 15 to 13 mid-scroll, an offset of 13 or 14 would briefly exceed the new limit. The checks also assume one event per cycle, held for exactly that cycle. The stimulus therefore changes the short-row and window-size inputs only while the scroll is idle, or in the case of window size, where it cannot affect the offset. Events are issued one at a time, each for a single clock.

// File: rtl/crs_pkg.sv
`timescale 1ns/1ps
package crs_pkg;
  typedef enum logic [2:0] {
    EV_NOP    = 3'd0,
    EV_CHAR   = 3'd1,
    EV_CR     = 3'd2,
    EV_START  = 3'd3,
    EV_RESUME = 3'd4,
    EV_ROLL   = 3'd5,
    EV_BASE   = 3'd6,
    EV_CHINT  = 3'd7
  } ev_code_t;
endpackage

// File: rtl/crs_window_calc.sv
`timescale 1ns/1ps
// Fits a block of rows ending at the base row; clamps to the rows above it.
module crs_window_calc #(
  parameter int RW = 4,
  parameter int NW = 4
) (
  input  logic [RW-1:0] base_row,
  input  logic [NW-1:0] want_rows,
  output logic [RW-1:0] top_row,
  output logic [NW-1:0] fit_rows
);
  logic [NW:0] span;
  logic [NW:0] fit_w;

  always_comb begin
    span  = (NW+1)'(base_row) + (NW+1)'(1);
    fit_w = ({1'b0, want_rows} > span) ? span : {1'b0, want_rows};
    fit_rows = NW'(fit_w);
    top_row  = RW'(span - fit_w);
  end
endmodule

// File: rtl/crs_scroll_unit.sv
`timescale 1ns/1ps
module crs_scroll_unit #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cancel,
  input  logic          frame,
  input  logic [LW-1:0] lines_per_row,
  output logic          active,
  output logic [LW-1:0] ofs
);
  logic [LW:0] ofs_next;
  assign ofs_next = {1'b0, ofs} + (LW+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ofs    <= '0;
    end else if (cancel) begin
      active <= 1'b0;
      ofs    <= '0;
    end else if (start) begin
      active <= 1'b1;
      ofs    <= '0;
    end else if (frame && active) begin
      if (ofs_next == {1'b0, lines_per_row}) begin
        active <= 1'b0;
        ofs    <= '0;
      end else begin
        ofs <= LW'(ofs_next);
      end
    end
  end

  AST_OFS_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (ofs < lines_per_row)); // R6
  AST_IDLE_OFS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !active |-> (ofs == '0)); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (start && !cancel) |=> (active && ofs == '0)); // R7
  AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !active); // R8
endmodule

// File: rtl/crs_cursor_unit.sv
`timescale 1ns/1ps
module crs_cursor_unit
  import crs_pkg::*;
#(
  parameter int ROWS     = 15,
  parameter int COLS     = 32,
  parameter int ROLL_MIN = 2,
  parameter int ROLL_MAX = 4,
  parameter int RW       = 4,
  parameter int CW       = 5,
  parameter int NW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_valid,
  input  ev_code_t      ev_code,
  input  logic [RW-1:0] ev_arg,
  input  logic [RW-1:0] txt_top,
  output logic [RW-1:0] base_q,
  output logic          mode_roll,
  output logic [NW-1:0] filled,
  output logic          frozen,
  output logic [RW-1:0] cur_row,
  output logic [CW-1:0] cur_col,
  output logic          wr_en,
  output logic [RW-1:0] wr_row,
  output logic [CW-1:0] wr_col,
  output logic          clr_req,
  output logic          shift_req,
  output logic          scroll_start,
  output logic          scroll_cancel
);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  logic [NW-1:0] roll_n;
  logic          roll_arg_ok;
  logic          base_arg_ok;
  logic          is_cr;

  assign roll_arg_ok = (32'(ev_arg) >= ROLL_MIN) && (32'(ev_arg) <= ROLL_MAX);
  assign base_arg_ok = (32'(ev_arg) < ROWS);
  assign is_cr       = ev_valid && (ev_code == EV_CR) && !frozen;

  assign scroll_start  = is_cr && (mode_roll || cur_row >= base_q);
  assign scroll_cancel = ev_valid && ((ev_code == EV_START) ||
                                      ((ev_code == EV_ROLL) && roll_arg_ok) ||
                                      ((ev_code == EV_BASE) && base_arg_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= LAST_ROW;
      mode_roll <= 1'b0;
      roll_n    <= NW'(ROLL_MIN);
      filled    <= NW'(1);
      frozen    <= 1'b0;
      cur_row   <= '0;
      cur_col   <= '0;
      wr_en     <= 1'b0;
      wr_row    <= '0;
      wr_col    <= '0;
      clr_req   <= 1'b0;
      shift_req <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      clr_req   <= 1'b0;
      shift_req <= 1'b0;
      if (ev_valid) begin
        case (ev_code)
          EV_CHAR: if (!frozen) begin
            wr_en  <= 1'b1;
            wr_row <= cur_row;
            wr_col <= cur_col;
            if (cur_col != LAST_COL) cur_col <= cur_col + CW'(1);
          end
          EV_CR: if (!frozen) begin
            cur_col <= '0;
            if (mode_roll) begin
              shift_req <= 1'b1;
              if (filled < roll_n) filled <= filled + NW'(1);
            end else if (cur_row < base_q) begin
              cur_row <= cur_row + RW'(1);
            end else begin
              shift_req <= 1'b1;
              cur_row   <= base_q;
            end
          end
          EV_START: begin
            clr_req   <= 1'b1;
            mode_roll <= 1'b0;
            frozen    <= 1'b0;
            cur_row   <= txt_top;
            cur_col   <= '0;
          end
          EV_RESUME: begin
            frozen    <= 1'b0;
            mode_roll <= 1'b0;
          end
          EV_ROLL: if (roll_arg_ok) begin
            mode_roll <= 1'b1;
            roll_n    <= NW'(ev_arg);
            filled    <= NW'(1);
            frozen    <= 1'b0;
            cur_row   <= base_q;
            cur_col   <= '0;
          end
          EV_BASE: if (base_arg_ok) begin
            base_q  <= ev_arg;
            cur_row <= ev_arg;
            cur_col <= '0;
          end
          EV_CHINT: frozen <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_COL_HOLD_AT_END: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_code == EV_CHAR && !frozen && cur_col == LAST_COL)
      |=> (cur_col == LAST_COL && wr_col == LAST_COL && wr_en)); // R3
  AST_FROZEN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (frozen && ev_valid && ev_code == EV_CHAR) |=> !wr_en); // R9
  AST_FROZEN_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (frozen && ev_valid && ev_code == EV_CR) |=> ($stable(cur_row) && !shift_req)); // R9
  AST_TEXT_CR_DOWN: assert property (@(posedge clk) disable iff (rst)
    (is_cr && !mode_roll && cur_row < base_q)
      |=> (cur_row == $past(cur_row) + RW'(1) && !shift_req)); // R4
  AST_ROLL_ON_BASE: assert property (@(posedge clk) disable iff (rst)
    mode_roll |-> (cur_row == base_q)); // R10
  AST_ROLL_FILL_CAP: assert property (@(posedge clk) disable iff (rst)
    mode_roll |-> (filled <= roll_n)); // R11
endmodule

// File: rtl/cap_row_scroll_ctrl.sv
`timescale 1ns/1ps
module cap_row_scroll_ctrl
  import crs_pkg::*;
#(
  parameter int ROWS        = 15,
  parameter int COLS        = 32,
  parameter int LINES_TALL  = 15,
  parameter int LINES_SHORT = 13,
  parameter int ROLL_MIN    = 2,
  parameter int ROLL_MAX    = 4,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int NW = $clog2(ROWS + 1),
  localparam int LW = $clog2(LINES_TALL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_valid,
  input  logic [2:0]    ev_code,
  input  logic [RW-1:0] ev_arg,
  input  logic          frame_strobe,
  input  logic [NW-1:0] cfg_win_rows,
  input  logic          cfg_short_rows,
  output logic          wr_en,
  output logic [RW-1:0] wr_row,
  output logic [CW-1:0] wr_col,
  output logic [RW-1:0] cur_row,
  output logic [CW-1:0] cur_col,
  output logic          clr_req,
  output logic          shift_req,
  output logic [RW-1:0] disp_top,
  output logic [NW-1:0] disp_rows,
  output logic          scroll_active,
  output logic [LW-1:0] scroll_ofs,
  output logic          frozen,
  output logic          roll_mode
);
  ev_code_t      ev_c;
  logic [NW-1:0] txt_n;
  logic [RW-1:0] base_q;
  logic [NW-1:0] filled;
  logic [RW-1:0] txt_top, roll_top;
  logic [NW-1:0] txt_rows, roll_rows;
  logic          s_start, s_cancel;
  logic [LW-1:0] lpr;

  assign ev_c  = ev_code_t'(ev_code);
  assign lpr   = cfg_short_rows ? LW'(LINES_SHORT) : LW'(LINES_TALL);
  assign txt_n = (cfg_win_rows == '0)           ? NW'(1)    :
                 (32'(cfg_win_rows) > ROWS)     ? NW'(ROWS) : cfg_win_rows;

  crs_window_calc #(.RW(RW), .NW(NW)) u_txt_win (
    .base_row(base_q), .want_rows(txt_n),
    .top_row(txt_top), .fit_rows(txt_rows)
  );

  crs_window_calc #(.RW(RW), .NW(NW)) u_roll_win (
    .base_row(base_q), .want_rows(filled),
    .top_row(roll_top), .fit_rows(roll_rows)
  );

  crs_cursor_unit #(
    .ROWS(ROWS), .COLS(COLS), .ROLL_MIN(ROLL_MIN), .ROLL_MAX(ROLL_MAX),
    .RW(RW), .CW(CW), .NW(NW)
  ) u_cursor (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_c), .ev_arg(ev_arg),
    .txt_top(txt_top), .base_q(base_q), .mode_roll(roll_mode), .filled(filled),
    .frozen(frozen), .cur_row(cur_row), .cur_col(cur_col),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .clr_req(clr_req), .shift_req(shift_req),
    .scroll_start(s_start), .scroll_cancel(s_cancel)
  );

  crs_scroll_unit #(.LW(LW)) u_scroll (
    .clk(clk), .rst(rst), .start(s_start), .cancel(s_cancel),
    .frame(frame_strobe), .lines_per_row(lpr),
    .active(scroll_active), .ofs(scroll_ofs)
  );

  assign disp_top  = roll_mode ? roll_top  : txt_top;
  assign disp_rows = roll_mode ? roll_rows : txt_rows;

  AST_SHIFT_STARTS_SCROLL: assert property (@(posedge clk) disable iff (rst)
    shift_req |-> (scroll_active && scroll_ofs == '0)); // R5
  AST_CLEAR_NOT_SCROLLING: assert property (@(posedge clk) disable iff (rst)
    clr_req |-> (!scroll_active && !frozen && !roll_mode)); // R8
endmodule

// File: tb/cap_row_scroll_ctrl_tb_top.sv
`timescale 1ns/1ps
module cap_row_scroll_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_code = 3'd0;
  logic [3:0] ev_arg = 4'd0;
  logic       frame_strobe = 1'b0;
  logic [3:0] cfg_win_rows = 4'd15;
  logic       cfg_short_rows = 1'b0;
  logic       wr_en, clr_req, shift_req, scroll_active, frozen, roll_mode;
  logic [3:0] wr_row, cur_row, disp_top, disp_rows, scroll_ofs;
  logic [4:0] wr_col, cur_col;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cap_row_scroll_ctrl dut_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code), .ev_arg(ev_arg),
    .frame_strobe(frame_strobe), .cfg_win_rows(cfg_win_rows),
    .cfg_short_rows(cfg_short_rows), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .cur_row(cur_row), .cur_col(cur_col), .clr_req(clr_req), .shift_req(shift_req),
    .disp_top(disp_top), .disp_rows(disp_rows), .scroll_active(scroll_active),
    .scroll_ofs(scroll_ofs), .frozen(frozen), .roll_mode(roll_mode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int code, input int arg);
    @(negedge clk);
    ev_valid = 1'b1; ev_code = 3'(code); ev_arg = 4'(arg);
    @(negedge clk);
    ev_valid = 1'b0; ev_code = 3'd0; ev_arg = 4'd0;
  endtask

  task automatic frame();
    @(negedge clk); frame_strobe = 1'b1;
    @(negedge clk); frame_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "cur_row", cur_row, 0);     chk("R1", "cur_col", cur_col, 0);
    chk("R1", "roll_mode", roll_mode, 0); chk("R1", "frozen", frozen, 0);
    chk("R1", "scroll_active", scroll_active, 0); chk("R1", "ofs", scroll_ofs, 0);
    chk("R1", "wr_en", wr_en, 0); chk("R1", "clr_req", clr_req, 0);
    chk("R1", "shift_req", shift_req, 0);
    chk("R1", "disp_top", disp_top, 0);   chk("R1", "disp_rows", disp_rows, 15);
  endtask

  task automatic t_chars();
    send(3, 0);
    chk("R8", "clr_req", clr_req, 1); chk("R8", "cur_row", cur_row, 0);
    for (int i = 0; i < 3; i++) begin
      send(1, 0);
      chk("R2", "wr_en", wr_en, 1); chk("R2", "wr_row", wr_row, 0);
      chk("R2", "wr_col", wr_col, i);
    end
    chk("R2", "cur_col", cur_col, 3);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 32; i++) send(1, 0);
    chk("R3", "wr_col", wr_col, 31); chk("R3", "cur_col", cur_col, 31);
    chk("R3", "wr_row", wr_row, 0);
  endtask

  task automatic t_fill();
    int shifts = 0;
    send(3, 0);
    for (int i = 0; i < 14; i++) begin
      send(2, 0);
      if (shift_req) shifts++;
    end
    chk("R4", "cur_row", cur_row, 14); chk("R4", "cur_col", cur_col, 0);
    chk("R4", "shifts", shifts, 0);
    send(2, 0);
    chk("R5", "shift_req", shift_req, 1); chk("R5", "active", scroll_active, 1);
    chk("R5", "ofs", scroll_ofs, 0);      chk("R5", "cur_row", cur_row, 14);
  endtask

  task automatic t_scroll_tall();
    for (int i = 0; i < 14; i++) frame();
    chk("R6", "ofs after 14", scroll_ofs, 14); chk("R6", "active", scroll_active, 1);
    frame();
    chk("R6", "active after 15", scroll_active, 0); chk("R6", "ofs", scroll_ofs, 0);
    frame();
    chk("R6", "idle frame ofs", scroll_ofs, 0); chk("R6", "idle active", scroll_active, 0);
  endtask

  task automatic t_scroll_short();
    cfg_short_rows = 1'b1;
    send(2, 0);
    chk("R5", "shift_req", shift_req, 1);
    for (int i = 0; i < 12; i++) frame();
    chk("R6", "short ofs 12", scroll_ofs, 12); chk("R6", "short active", scroll_active, 1);
    frame();
    chk("R6", "short done", scroll_active, 0);
    cfg_short_rows = 1'b0;
  endtask

  task automatic t_early_cr();
    send(2, 0);
    for (int i = 0; i < 5; i++) frame();
    chk("R7", "ofs before", scroll_ofs, 5);
    send(2, 0);
    chk("R7", "ofs reset", scroll_ofs, 0); chk("R7", "shift_req", shift_req, 1);
    chk("R7", "active", scroll_active, 1);
    send(3, 0);
    chk("R8", "clr_req", clr_req, 1); chk("R8", "active", scroll_active, 0);
    chk("R8", "cur_row", cur_row, 0);
  endtask

  task automatic t_freeze();
    send(1, 0); send(1, 0); send(2, 0); send(1, 0);
    chk("R9", "pre cur_row", cur_row, 1); chk("R9", "pre cur_col", cur_col, 1);
    send(7, 0);
    chk("R9", "frozen", frozen, 1);
    send(1, 0);
    chk("R9", "frozen wr_en", wr_en, 0); chk("R9", "frozen col", cur_col, 1);
    send(2, 0);
    chk("R9", "frozen row", cur_row, 1); chk("R9", "frozen shift", shift_req, 0);
    send(4, 0);
    chk("R9", "resumed", frozen, 0);
    send(1, 0);
    chk("R9", "resume wr_en", wr_en, 1); chk("R9", "resume row", wr_row, 1);
    chk("R9", "resume col", wr_col, 1);
  endtask

  task automatic t_window();
    cfg_win_rows = 4'd4;
    send(6, 9);
    chk("R12", "cur_row", cur_row, 9);  chk("R12", "cur_col", cur_col, 0);
    chk("R13", "disp_top", disp_top, 6); chk("R13", "disp_rows", disp_rows, 4);
    send(3, 0);
    chk("R8", "window top", cur_row, 6);
    for (int i = 0; i < 3; i++) send(2, 0);
    chk("R4", "window bottom", cur_row, 9); chk("R4", "no shift", shift_req, 0);
    send(2, 0);
    chk("R5", "window shift", shift_req, 1);
    cfg_win_rows = 4'd0;
    #1 chk("R13", "zero rows", disp_rows, 1); chk("R13", "zero top", disp_top, 9);
    cfg_win_rows = 4'd15;
    #1 chk("R13", "clamped rows", disp_rows, 10); chk("R13", "clamped top", disp_top, 0);
    send(6, 15);
    chk("R12", "ignored base row", cur_row, 9); chk("R12", "ignored keeps scroll", scroll_active, 1);
    send(6, 9);
    chk("R12", "base cancels scroll", scroll_active, 0);
  endtask

  task automatic t_roll();
    send(6, 12);
    send(5, 3);
    chk("R10", "roll_mode", roll_mode, 1); chk("R10", "cur_row", cur_row, 12);
    chk("R10", "rows", disp_rows, 1);      chk("R10", "top", disp_top, 12);
    send(1, 0);
    chk("R2", "roll wr_row", wr_row, 12);
    send(2, 0);
    chk("R11", "shift 1", shift_req, 1); chk("R11", "rows 2", disp_rows, 2);
    chk("R11", "top 11", disp_top, 11);  chk("R11", "col 0", cur_col, 0);
    send(2, 0);
    chk("R11", "rows 3", disp_rows, 3);  chk("R11", "top 10", disp_top, 10);
    send(2, 0);
    chk("R11", "shift cap", shift_req, 1); chk("R11", "rows cap", disp_rows, 3);
    send(5, 5);
    chk("R10", "bad arg mode", roll_mode, 1); chk("R10", "bad arg rows", disp_rows, 3);
    send(5, 2);
    chk("R10", "two rows reset", disp_rows, 1);
    send(2, 0); send(2, 0);
    chk("R11", "two cap", disp_rows, 2); chk("R11", "two top", disp_top, 11);
    send(3, 0);
    chk("R8", "text again", roll_mode, 0); chk("R8", "text top", cur_row, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_chars();
    t_saturate();
    t_fill();
    t_scroll_tall();
    t_scroll_short();
    t_early_cr();
    t_freeze();
    t_window();
    t_roll();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule